// File: doc/BRIEF.md
# Signed-Amount Bidirectional Accumulator Shifter

This block shifts a 40-bit accumulator by a distance and direction taken from one 16-bit control word. The upstream datapath picks the control word, either the middle word of the other accumulator or an auxiliary high word, and presents it here. A mode input picks arithmetic or logical behaviour. The block returns the shifted accumulator together with three flags computed from that result.

Bits 6:0 of the control word form a signed 7-bit field. A non-negative value shifts left by that amount. A negative value shifts right by the magnitude of the field, which works out to 64 minus bits 5:0. The one negative code with all-zero low bits performs no shift. With the default parameters the result is registered and appears one cycle after the request. A parameter can instead make the block purely combinational.

Top module: `acc_shifter`

## Requirements
- R1: When control bit 6 is 0, the result is the accumulator shifted left by control bits 5:0. The vacated low bits are 0, bits moved past bit 39 are lost, and any left distance of 40 or more gives all zeros in both modes.
- R2: When control bit 6 is 1 and bits 5:0 are not zero, the result is the accumulator shifted right by 64 minus bits 5:0.
- R3: When control bit 6 is 1 and bits 5:0 are zero, the result equals the input accumulator.
- R4: On a right shift, `arith`=1 fills the vacated high bits with copies of input bit 39, and `arith`=0 fills them with zeros. A right distance of 40 or more gives all copies of bit 39 when `arith`=1 and all zeros when `arith`=0.
- R5: Control bits 15:7 have no effect on the result or the flags.
- R6: `flag_zero` is 1 exactly when the result is zero. `flag_neg` equals result bit 39. `flag_wide` is 1 when result bits 39:31 are not all equal, meaning the value does not fit in 32 signed bits.
- R7: In registered mode, a request with `in_valid`=1 at a clock edge updates the result and flags at that edge, and `out_valid` is 1 for the following cycle. Without a request, `out_valid` is 0 and the result and flags hold their values.
- R8: While `rst_n` is low, `out_valid`, `acc_out` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Shift request this cycle |
| acc_in | input | 40 | Accumulator to shift |
| ctl_word | input | 16 | Control word; bits 6:0 give direction and distance |
| arith | input | 1 | 1 = arithmetic right fill, 0 = logical |
| out_valid | output | 1 | Result produced by the previous cycle's request |
| acc_out | output | 40 | Shifted accumulator |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result bit 39 |
| flag_wide | output | 1 | Result bits 39:31 not all equal |

## Verification
Every result and flag passes through one register. A request driven on a falling edge is captured on the next rising edge, and the bench compares `acc_out`, the flags and `out_valid` at the falling edge that follows. Each request is checked exactly one cycle after it is made. Hold behaviour is checked on a cycle with no request: the inputs are changed and the outputs are observed one edge later, where they must be unchanged and `out_valid` must be 0.

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int ACC_W      = 40,
  parameter int CTL_W      = 16,
  parameter int FIELD_W    = 7,
  parameter int NARROW_W   = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             arith,
  output logic             out_valid,
  output logic [ACC_W-1:0] acc_out,
  output logic             flag_zero,
  output logic             flag_neg,
  output logic             flag_wide
);
  localparam int AMT_W = FIELD_W - 1;
  localparam int TOP_W = ACC_W - NARROW_W + 1;

  logic             go_right;
  logic [AMT_W-1:0] mag;
  logic [AMT_W-1:0] rdist;
  logic             fill;
  logic [ACC_W-1:0] res;
  logic [TOP_W-1:0] top;
  logic             z_n, neg_n, wide_n;

  assign go_right = ctl_word[AMT_W];
  assign mag      = ctl_word[AMT_W-1:0];
  assign rdist    = '0 - mag;
  assign fill     = arith & acc_in[ACC_W-1];

  always_comb begin
    if (!go_right) begin
      if (int'(mag) >= ACC_W) res = '0;
      else                    res = acc_in << mag;
    end else if (int'(rdist) >= ACC_W) begin
      res = {ACC_W{fill}};
    end else if (arith) begin
      res = $signed(acc_in) >>> rdist;
    end else begin
      res = acc_in >> rdist;
    end
  end

  assign top    = res[ACC_W-1:NARROW_W-1];
  assign z_n    = ~|res;
  assign neg_n  = res[ACC_W-1];
  assign wide_n = ~(&top | ~|top);

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        acc_out   <= '0;
        flag_zero <= 1'b0;
        flag_neg  <= 1'b0;
        flag_wide <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          acc_out   <= res;
          flag_zero <= z_n;
          flag_neg  <= neg_n;
          flag_wide <= wide_n;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign acc_out   = res;
    assign flag_zero = z_n;
    assign flag_neg  = neg_n;
    assign flag_wide = wide_n;
  end
endmodule

// File: rtl/acc_shifter_chk.sv
module acc_shifter_chk #(
  parameter int ACC_W      = 40,
  parameter int CTL_W      = 16,
  parameter bit REGISTERED = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [ACC_W-1:0] acc_in,
  input logic [CTL_W-1:0] ctl_word,
  input logic             arith,
  input logic             out_valid,
  input logic [ACC_W-1:0] acc_out,
  input logic             flag_zero,
  input logic             flag_neg,
  input logic             flag_wide
);
  if (REGISTERED) begin : g_chk
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(acc_out) && $stable(flag_zero));
    p_zero_right_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ctl_word[6] && ctl_word[5:0] == 6'd0 |=> acc_out == $past(acc_in));
    p_left_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !ctl_word[6] && ctl_word[5:0] != 6'd0 |=> !acc_out[0]);
    p_logic_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ctl_word[6] && ctl_word[5:0] != 6'd0 && !arith |=> !acc_out[ACC_W-1]);
    p_arith_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ctl_word[6] && arith |=> acc_out[ACC_W-1] == $past(acc_in[ACC_W-1]));
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> flag_zero == (acc_out == '0));
    p_neg_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> flag_neg == acc_out[ACC_W-1]);
  end
endmodule

bind acc_shifter acc_shifter_chk #(.ACC_W(ACC_W), .CTL_W(CTL_W), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in), .ctl_word(ctl_word),
  .arith(arith), .out_valid(out_valid), .acc_out(acc_out), .flag_zero(flag_zero),
  .flag_neg(flag_neg), .flag_wide(flag_wide));

// File: tb/tb_acc_shifter.sv
module tb_acc_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] acc_in = '0;
  logic [15:0] ctl_word = '0;
  logic        arith = 1'b0;
  logic        out_valid;
  logic [39:0] acc_out;
  logic        flag_zero, flag_neg, flag_wide;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in), .ctl_word(ctl_word),
    .arith(arith), .out_valid(out_valid), .acc_out(acc_out), .flag_zero(flag_zero),
    .flag_neg(flag_neg), .flag_wide(flag_wide));

  function automatic logic [39:0] ref_shift(logic [39:0] a, logic [15:0] c, logic ar);
    logic [39:0] r;
    int n;
    if (!c[6]) begin
      n = int'(c[5:0]);
      for (int i = 0; i < 40; i++) r[i] = (i - n >= 0) ? a[i-n] : 1'b0;
    end else begin
      n = (c[5:0] == 6'd0) ? 0 : 64 - int'(c[5:0]);
      for (int i = 0; i < 40; i++) r[i] = (i + n < 40) ? a[i+n] : (ar & a[39]);
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [39:0] a, logic [15:0] c, logic ar, string req);
    logic [39:0] e;
    e = ref_shift(a, c, ar);
    acc_in = a; ctl_word = c; arith = ar; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " result"}, 64'(acc_out), 64'(e));
    check("R7 valid", 64'(out_valid), 64'd1);
    check("R6 zero flag", 64'(flag_zero), 64'(e == '0));
    check("R6 neg flag", 64'(flag_neg), 64'(e[39]));
    check("R6 wide flag", 64'(flag_wide), 64'(!(&e[39:31] || ~|e[39:31])));
  endtask

  initial begin
    logic [39:0] a;
    logic [15:0] c;
    logic [39:0] held;
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    check("R8 valid", 64'(out_valid), 64'd0);
    check("R8 acc", 64'(acc_out), 64'd0);
    check("R8 flags", 64'({flag_zero, flag_neg, flag_wide}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(40'h00_1234_5678, 16'h0004, 1'b0, "R1 left 4");
    apply(40'hFF_FFFF_FFFF, 16'h0027, 1'b1, "R1 left 39");
    apply(40'hAB_CDEF_0123, 16'h0028, 1'b0, "R1 left 40 zero");
    apply(40'hAB_CDEF_0123, 16'h003F, 1'b1, "R1 left 63 zero");
    apply(40'h80_0000_0000, 16'h007F, 1'b0, "R2 logical right 1");
    apply(40'h80_0000_0000, 16'h007F, 1'b1, "R4 arith right 1");
    apply(40'h81_2345_6789, 16'h0070, 1'b1, "R2 arith right 16");
    apply(40'h81_2345_6789, 16'h0058, 1'b1, "R4 arith right 40");
    apply(40'h81_2345_6789, 16'h0058, 1'b0, "R4 logical right 40");
    apply(40'h81_2345_6789, 16'h0041, 1'b1, "R4 arith right 63");
    apply(40'h9A_BCDE_F012, 16'h0040, 1'b1, "R3 encoded zero right");
    apply(40'h9A_BCDE_F012, 16'h0000, 1'b0, "R1 left zero");
    apply(40'h00_0000_0000, 16'h0001, 1'b0, "R6 zero result");
    apply(40'h12_3456_789A, 16'hFF84, 1'b0, "R5 upper bits set");
    check("R5 same as clean", 64'(acc_out), 64'(ref_shift(40'h12_3456_789A, 16'h0004, 1'b0)));

    held = acc_out;
    acc_in = 40'h55_5555_5555; ctl_word = 16'h0001;
    @(negedge clk);
    check("R7 hold acc", 64'(acc_out), 64'(held));
    check("R7 idle valid", 64'(out_valid), 64'd0);

    for (int k = 0; k < 400; k++) begin
      a = {$urandom, $urandom} [39:0];
      c = 16'($urandom);
      if (k % 3 == 0) c[5:0] = 6'($urandom_range(0, 8));
      apply(a, c, 1'($urandom), c[6] ? "R2 random right" : "R1 random left");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule